// File: doc/BRIEF.md
# Audio Serial Master Bit-Clock and Channel-Select Generator

This block is the timing core of an audio serial link that always drives the clocks. It receives a system clock running at twice the wanted bit-clock rate and divides it by two to make the serial bit clock (SCK). From that clock it derives the channel-select line (WS), low while the left sample is on the wire and high while the right one is. The frame length, meaning the number of SCK cycles that carry one left sample and one right sample together, is a compile-time parameter taking 16, 32, 48 or 64. For 48 kHz audio with a 64-cycle frame, the input clock must be 2 x 48 kHz x 64 = 6.144 MHz.

Besides the two link clocks, the block gives the data paths one-cycle timing strobes. One fires in the input cycle that ends with each SCK falling edge, where a transmitter shifts out its next bit. One fires in the cycle that ends with each SCK rising edge, where a receiver samples. Two more mark the WS falling edge (frame start) and the WS rising edge (half frame). An 8-bit control write port carries a global run bit and per-direction enables. The direction enables are passed on to the data paths only at frame boundaries, so whole left/right pairs are always moved. While stopped, every output is held at 0. Each start begins at a known phase, at the start of a left half.

Top module: `i2s_clkgen_master`

## Requirements
- R1: While running, SCK toggles on every input clock edge, so one SCK period lasts exactly two input clock cycles.
- R2: In the first cycle after a write that sets the run bit while stopped, SCK is 0, WS is 0 and the sample strobe is 1. SCK first rises at the next edge, and the frame starts at the beginning of a left half.
- R3: After reset, and from the cycle after a write that clears the run bit, SCK, WS, all four strobes and both direction-active outputs are 0.
- R4: While running, WS is 0 for the first WS_PERIOD/2 SCK cycles of each frame and 1 for the remaining WS_PERIOD/2, and this pattern repeats. WS_PERIOD is 16, 32, 48 or 64, with 32 as the default.
- R5: WS changes only at the input clock edge where SCK falls.
- R6: The frame strobe is 1 exactly in the input cycle that ends with the edge where WS falls. The half strobe is 1 exactly in the cycle that ends with the edge where WS rises.
- R7: The shift strobe is 1 in every input cycle that ends with an SCK falling edge. The sample strobe is 1 in every input cycle that ends with an SCK rising edge. The two are never 1 together.
- R8: Control write data: bit 2 is run, bit 1 is the receive enable, bit 0 is the transmit enable. Bits 7 to 3 have no effect. A write that keeps run at 1 while already running does not restart the timing.
- R9: While running, the transmit and receive active outputs take the values of control bits 0 and 1 only at the edge that ends a frame-strobe cycle. On a stopped-to-running write, they load directly from the written bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, twice the SCK rate |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control write data (bit 2 run, bit 1 rx, bit 0 tx) |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Channel select, 0 left, 1 right |
| shift_stb | output | 1 | Cycle ending with an SCK falling edge |
| sample_stb | output | 1 | Cycle ending with an SCK rising edge |
| frame_stb | output | 1 | Cycle ending with the WS falling edge |
| half_stb | output | 1 | Cycle ending with the WS rising edge |
| tx_active | output | 1 | Transmit enable, applied at frame boundaries |
| rx_active | output | 1 | Receive enable, applied at frame boundaries |

## Verification
The generator is run free over several whole frames, both at the default 32-cycle frame and in a second instance with a 48-cycle frame. The 48-cycle case separates a correct count wrap from one that only works at powers of two. Control writes land mid-frame, with reserved bits set, with run set again while already running, and as stop-then-start pairs. These patterns distinguish deferred from immediate enable updates, a true restart from a continued phase, and real masking of the reserved bits. Every output is compared on every cycle against a count-based model kept in the bench.

// File: rtl/i2s_clkgen_pkg.sv
package i2s_clkgen_pkg;
  localparam int CfgRunBit = 2;
  localparam int CfgRxBit  = 1;
  localparam int CfgTxBit  = 0;

  // next SCK index within a frame, wrapping at the frame length
  function automatic int idx_next(int idx, int period);
    return (idx >= period - 1) ? 0 : idx + 1;
  endfunction

  // channel for a given SCK index: 1 means right half
  function automatic logic in_right(int idx, int period);
    return idx >= (period / 2);
  endfunction
endpackage

// File: rtl/i2s_ctrl_reg.sv
module i2s_ctrl_reg
  import i2s_clkgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic       frame_ev,
  output logic       run,
  output logic       tx_act,
  output logic       rx_act
);
  logic run_q, rx_req, tx_req, rx_q, tx_q;
  logic unused_bits;
  assign unused_bits = ^wdata[7:3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      rx_req <= 1'b0;
      tx_req <= 1'b0;
      rx_q   <= 1'b0;
      tx_q   <= 1'b0;
    end else begin
      if (we) begin
        run_q  <= wdata[CfgRunBit];
        rx_req <= wdata[CfgRxBit];
        tx_req <= wdata[CfgTxBit];
      end
      if (we && !wdata[CfgRunBit]) begin
        rx_q <= 1'b0;
        tx_q <= 1'b0;
      end else if (we && !run_q) begin
        rx_q <= wdata[CfgRxBit];
        tx_q <= wdata[CfgTxBit];
      end else if (!run_q) begin
        rx_q <= 1'b0;
        tx_q <= 1'b0;
      end else if (frame_ev) begin
        rx_q <= rx_req;
        tx_q <= tx_req;
      end
    end
  end

  assign run    = run_q;
  assign rx_act = rx_q;
  assign tx_act = tx_q;
endmodule

// File: rtl/i2s_bit_timer.sv
module i2s_bit_timer
  import i2s_clkgen_pkg::*;
#(
  parameter int PERIOD = 32,
  localparam int CW = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic          sck_r,
  output logic [CW-1:0] bit_idx,
  output logic          rise_ev,
  output logic          fall_ev
);
  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      sck_r   <= 1'b0;
      bit_idx <= '0;
    end else begin
      sck_r <= ~sck_r;
      if (sck_r) bit_idx <= CW'(idx_next(int'(bit_idx), PERIOD));
    end
  end

  assign rise_ev = run & ~sck_r;
  assign fall_ev = run & sck_r;
endmodule

// File: rtl/i2s_ws_gen.sv
module i2s_ws_gen
  import i2s_clkgen_pkg::*;
#(
  parameter int PERIOD = 32,
  localparam int CW = $clog2(PERIOD),
  localparam int HALF = PERIOD / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          fall_ev,
  input  logic [CW-1:0] bit_idx,
  output logic          ws_r,
  output logic          frame_ev,
  output logic          half_ev
);
  always_ff @(posedge clk) begin
    if (!rst_n || !run) ws_r <= 1'b0;
    else if (fall_ev) ws_r <= in_right(idx_next(int'(bit_idx), PERIOD), PERIOD);
  end

  assign frame_ev = fall_ev & (bit_idx == CW'(PERIOD - 1));
  assign half_ev  = fall_ev & (bit_idx == CW'(HALF - 1));
endmodule

// File: rtl/i2s_clkgen_master.sv
module i2s_clkgen_master #(
  parameter int WS_PERIOD = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic       sck,
  output logic       ws,
  output logic       shift_stb,
  output logic       sample_stb,
  output logic       frame_stb,
  output logic       half_stb,
  output logic       tx_active,
  output logic       rx_active
);
  localparam int CW = $clog2(WS_PERIOD);

  logic          run_w, sck_w, ws_w, rise_w, fall_w, frame_w, half_w;
  logic [CW-1:0] idx_w;

  i2s_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .frame_ev(frame_w), .run(run_w), .tx_act(tx_active), .rx_act(rx_active)
  );

  i2s_bit_timer #(.PERIOD(WS_PERIOD)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run_w), .sck_r(sck_w),
    .bit_idx(idx_w), .rise_ev(rise_w), .fall_ev(fall_w)
  );

  i2s_ws_gen #(.PERIOD(WS_PERIOD)) u_ws (
    .clk(clk), .rst_n(rst_n), .run(run_w), .fall_ev(fall_w),
    .bit_idx(idx_w), .ws_r(ws_w), .frame_ev(frame_w), .half_ev(half_w)
  );

  assign sck        = sck_w & run_w;
  assign ws         = ws_w & run_w;
  assign shift_stb  = fall_w;
  assign sample_stb = rise_w;
  assign frame_stb  = frame_w;
  assign half_stb   = half_w;
endmodule

// File: rtl/i2s_clkgen_chk.sv
module i2s_clkgen_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic sck,
  input logic ws,
  input logic shift_stb,
  input logic sample_stb,
  input logic frame_stb,
  input logic half_stb,
  input logic tx_active,
  input logic rx_active
);
  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !(sck | ws | shift_stb | sample_stb | frame_stb | half_stb | tx_active | rx_active));

  // R1
  sck_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> (sck != $past(sck)));

  // R5
  ws_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (ws != $past(ws))) |-> $past(shift_stb));

  // R6
  frame_ws_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |-> (ws && !half_stb));

  // R6
  frame_then_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> !ws);

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shift_stb, sample_stb}));

  // R9
  tx_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (tx_active != $past(tx_active))) |-> $past(frame_stb));

  // R9
  rx_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (rx_active != $past(rx_active))) |-> $past(frame_stb));
endmodule

bind i2s_clkgen_master i2s_clkgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_w), .sck(sck), .ws(ws),
  .shift_stb(shift_stb), .sample_stb(sample_stb), .frame_stb(frame_stb),
  .half_stb(half_stb), .tx_active(tx_active), .rx_active(rx_active)
);

// File: tb/sim_i2s_clkgen_master.sv
`timescale 1ns/1ps
module sim_i2s_clkgen_master;
  localparam int P0 = 32;
  localparam int P1 = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [7:0] wd = 8'h00;
  always #2 clk = ~clk;

  logic sck0, ws0, sh0, sa0, fr0, hf0, tx0, rx0;
  logic sck1, ws1, sh1, sa1, fr1, hf1, tx1, rx1;

  i2s_clkgen_master #(.WS_PERIOD(P0)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(we), .cfg_wdata(wd),
    .sck(sck0), .ws(ws0), .shift_stb(sh0), .sample_stb(sa0),
    .frame_stb(fr0), .half_stb(hf0), .tx_active(tx0), .rx_active(rx0));

  i2s_clkgen_master #(.WS_PERIOD(P1)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_we(we), .cfg_wdata(wd),
    .sck(sck1), .ws(ws1), .shift_stb(sh1), .sample_stb(sa1),
    .frame_stb(fr1), .half_stb(hf1), .tx_active(tx1), .rx_active(rx1));

  int total = 0;
  int bad = 0;
  bit done = 0;

  // behavioural model: cycles since start, held requests and active bits
  bit run_m = 0;
  int t = 0;
  bit rxq = 0, txq = 0, rxa = 0, txa = 0;

  function automatic bit e_sck(); return run_m && (t % 2 == 1); endfunction
  function automatic int e_cnt(int p); return (t / 2) % p; endfunction
  function automatic bit e_ws(int p); return run_m && (e_cnt(p) >= p / 2); endfunction
  function automatic bit e_fr(int p); return e_sck() && (e_cnt(p) == p - 1); endfunction
  function automatic bit e_hf(int p); return e_sck() && (e_cnt(p) == p / 2 - 1); endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      run_m = 0; t = 0; rxq = 0; txq = 0; rxa = 0; txa = 0;
    end else begin
      automatic bit fs = e_fr(P0);
      if (we && wd[2] && !run_m) begin
        run_m = 1; t = 0; rxa = wd[1]; txa = wd[0];
      end else if (we && !wd[2]) begin
        run_m = 0; t = 0; rxa = 0; txa = 0;
      end else if (run_m) begin
        t++;
        if (fs) begin rxa = rxq; txa = txq; end
      end
      if (we) begin rxq = wd[1]; txq = wd[0]; end
    end
  end

  task automatic chk(bit act, bit exp, string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0d actual=%0b expected=%0b", req, t, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (!run_m) begin
        chk(sck0 | ws0 | sh0 | sa0 | fr0 | hf0 | tx0 | rx0, 1'b0, "R3 idle u0");
        chk(sck1 | ws1 | sh1 | sa1 | fr1 | hf1, 1'b0, "R3 idle u1");
      end else begin
        chk(sck0, e_sck(), "R1 sck u0");
        chk(ws0, e_ws(P0), "R4/R5 ws u0");
        chk(sh0, e_sck(), "R7 shift u0");
        chk(sa0, !e_sck(), "R7 sample u0");
        chk(fr0, e_fr(P0), "R6 frame u0");
        chk(hf0, e_hf(P0), "R6 half u0");
        chk(tx0, txa, "R9 tx_active");
        chk(rx0, rxa, "R9 rx_active");
        chk(sck1, e_sck(), "R1 sck u1");
        chk(ws1, e_ws(P1), "R4/R5 ws u1");
        chk(fr1, e_fr(P1), "R6 frame u1");
        chk(hf1, e_hf(P1), "R6 half u1");
      end
    end
  end

  task automatic wr(logic [7:0] v);
    @(negedge clk);
    we = 1'b1; wd = v;
    @(negedge clk);
    we = 1'b0; wd = 8'h00;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R3: reset state
    chk(sck0 | ws0 | tx0 | rx0 | sh0 | sa0, 1'b0, "R3 reset state");
    rst_n = 1'b1;
    idle(4);
    // R2: start with no direction enabled, check phase right after write
    @(negedge clk); we = 1'b1; wd = 8'h04;
    @(negedge clk); we = 1'b0; wd = 8'h00;
    chk(sck0, 1'b0, "R2 start sck");
    chk(ws0, 1'b0, "R2 start ws");
    chk(sa0, 1'b1, "R2 start sample");
    @(negedge clk);
    chk(sck0, 1'b1, "R2 first rise");
    idle(150);
    // R9: enable both mid-frame, must wait for frame boundary
    wr(8'h07);
    chk(tx0, 1'b0, "R9 deferred tx");
    idle(200);
    chk(tx0, 1'b1, "R9 tx applied");
    chk(rx0, 1'b1, "R9 rx applied");
    // R8: reserved bits set, run kept: no restart, directions off at frame
    wr(8'hFC);
    idle(220);
    // R8: stop then write with run clear and reserved bits set
    wr(8'h00);
    idle(10);
    wr(8'hFB);
    idle(20);
    chk(sck0 | ws0, 1'b0, "R8 reserved bits ignored");
    // R2/R9: start with tx only, loaded directly
    wr(8'h05);
    chk(tx0, 1'b1, "R9 direct load tx");
    chk(rx0, 1'b0, "R9 direct load rx");
    idle(97);
    // stop/start back to back: restart phase
    @(negedge clk); we = 1'b1; wd = 8'h00;
    @(negedge clk); wd = 8'h06;
    @(negedge clk); we = 1'b0; wd = 8'h00;
    chk(sck0, 1'b0, "R2 restart sck");
    chk(sa0, 1'b1, "R2 restart sample");
    idle(300);
    wr(8'h00);
    idle(8);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule